// File: doc/BRIEF.md
# Multicycle accumulator CPU sequencer

This block is the control unit and datapath of a small 8-bit accumulator processor with a 16-bit byte address space. It holds the program counter (PC), the address register (AR), the data register (DR), a temporary register (TR), the instruction register (IR), the accumulator (AC), a general register (R) and four flags: Z, C, V and N. Every memory access goes through AR, which supplies the address, and through DR, which holds the data. Each instruction runs as a fixed sequence of one-cycle subcycles. An ALU submodule computes the arithmetic, logic, shift and rotate results.

The memory port uses a combinational read: `mem_rdata` must show the byte at `mem_addr` during the same cycle. Writes are synchronous and take effect on the clock edge while `mem_we` is high.

The state machine has these states and transitions:
- **Fetch.** `S_F1` (AR←PC) goes to `S_F2`. `S_F2` (DR←mem, PC+1) goes to `S_F3`. `S_F3` (IR←DR, AR←PC) then dispatches on the opcode.
- **Address operand.** `S_A1` (DR←mem, PC+1, AR+1) goes to `S_A2`. `S_A2` (TR←DR, DR←mem, PC+1) goes to `S_JP3` for jumps and to `S_A3` (AR←{TR,DR}) otherwise.
- **Load.** `S_A3` goes to `S_LD4` (DR←mem), then to `S_LD5` (AC←DR), then back to `S_F1`.
- **Store.** `S_A3` goes to `S_ST4` (DR←AC), then to `S_ST5` (one-cycle write strobe), then back to `S_F1`.
- **Jump.** `S_JP3` loads PC only if the condition holds, then returns to `S_F1`.
- **Immediate load.** `S_IM1` (DR←mem, PC+1) goes to `S_IM2` (AC←DR), then back to `S_F1`.
- **Register and ALU operations.** `S_EX` executes in one cycle, then returns to `S_F1`.
- **Halt.** `S_HLT` is terminal and holds until reset.

Top module: `acc_cpu_seq`

## Requirements
- R1: Asynchronous active-low reset clears PC, AR, the other registers and all four flags. While reset is held, `halted` and `mem_we` are low, and the first fetch reads address 0x0000.
- R2: Fetch takes three cycles. NOP (0x00) and any opcode not listed in these requirements (for example 0x20) only advance PC, so each takes exactly 3 cycles.
- R3: LDAC (0x01) reads a 16-bit address from the two bytes after the opcode, high byte first. It loads AC with the byte at that address and takes 8 cycles in total.
- R4: STAC (0x02) forms its address the same way as LDAC and writes AC there. It takes 8 cycles, and `mem_we` is high for exactly one cycle with `mem_wdata` equal to AC.
- R5: MVI (0x13) loads AC with the byte after the opcode and takes 5 cycles. MVAC (0x03) copies AC into R, MOVR (0x04) copies R into AC, and each takes 4 cycles.
- R6: JUMP (0x05) loads PC with its address operand and takes 6 cycles.
- R7: The conditional jumps are JMPZ 0x06 (Z=1), JPNZ 0x07 (Z=0), JMPC 0x10 (C=1), JMPV 0x11 (V=1) and JMPN 0x12 (N=1). Each takes 6 cycles. When its condition is false, execution continues 3 bytes past the opcode.
- R8: ADD (0x08, AC+R), SUB (0x09, AC−R), INAC (0x0A, AC+1) and CLAC (0x0B, AC←0) update all four flags. Z means the result is zero and N is bit 7 of the result. C is the carry out for addition and the borrow for subtraction. V is signed overflow. CLAC clears C and V.
- R9: AND (0x0C), OR (0x0D), XOR (0x0E) and NOT (0x0F) combine AC with R (NOT complements AC). They update only Z and N, and leave C and V unchanged.
- R10: LSL (0x14), LSR (0x15), RL (0x16) and RR (0x17) shift or rotate AC by one bit. Shifts fill the vacated bit with zero. C receives the bit moved out, V is set when bit 7 changes, and Z and N follow the result.
- R11: HALT (0xFF) raises `halted` after its 3 fetch cycles. `halted` stays high until reset, with no further writes and a constant `mem_addr`.
- R12: ALU instructions take 4 cycles, so instruction cycle counts add up: MVI, MVAC, JUMP and HALT in sequence take 18 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address, driven from AR |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| mem_wdata | output | 8 | Write data, driven from DR |
| mem_we | output | 1 | Write strobe, one cycle per store |
| halted | output | 1 | High once HALT has executed |

## Verification
The assertions take for granted two things about the inputs. First, `mem_rdata` is a defined byte that matches `mem_addr` within the same cycle. Second, reset is held long enough for the program image to be written before the first fetch.

The bench memory model is a combinational-read, synchronous-write array loaded only while reset is held, so the design never reads an undefined value. The test programs therefore stay inside these assumptions. Every jump in a program targets a decoded instruction, and the only undefined opcode used is 0x20, placed on purpose to check that it behaves as a NOP.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [3:0] {
        S_F1, S_F2, S_F3, S_A1, S_A2, S_A3, S_LD4, S_LD5,
        S_ST4, S_ST5, S_JP3, S_IM1, S_IM2, S_EX, S_HLT
    } state_e;

    typedef enum logic [3:0] {
        A_ADD, A_SUB, A_INC, A_CLR, A_AND, A_OR, A_XOR, A_NOT,
        A_LSL, A_LSR, A_RL, A_RR
    } alu_op_e;

    typedef enum logic [3:0] {
        K_NOP, K_LDAC, K_STAC, K_JMP, K_MVI, K_MVAC, K_MOVR, K_ALU, K_HALT
    } kind_e;

    typedef enum logic [2:0] {
        J_ALW, J_Z, J_NZ, J_C, J_V, J_N
    } cond_e;
endpackage

// File: rtl/acc_cpu_dec.sv
module acc_cpu_dec
    import acc_cpu_pkg::*;
(
    input  logic [7:0] opc,
    output kind_e      kind,
    output alu_op_e    aop,
    output cond_e      cond
);
    always_comb begin
        kind = K_NOP;
        aop  = A_ADD;
        cond = J_ALW;
        unique casez (opc)
            8'h01: kind = K_LDAC;
            8'h02: kind = K_STAC;
            8'h03: kind = K_MVAC;
            8'h04: kind = K_MOVR;
            8'h05: kind = K_JMP;
            8'h06: begin kind = K_JMP; cond = J_Z;  end
            8'h07: begin kind = K_JMP; cond = J_NZ; end
            8'h10: begin kind = K_JMP; cond = J_C;  end
            8'h11: begin kind = K_JMP; cond = J_V;  end
            8'h12: begin kind = K_JMP; cond = J_N;  end
            8'h13: kind = K_MVI;
            8'b0000_1???: begin kind = K_ALU; aop = alu_op_e'({1'b0, opc[2:0]}); end
            8'b0001_01??: begin kind = K_ALU; aop = alu_op_e'({2'b10, opc[1:0]}); end
            8'hFF: kind = K_HALT;
            default: kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           c_o,
    output logic           v_o,
    output logic           cv_upd
);
    localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};
    logic [W:0] ext;

    always_comb begin
        ext    = '0;
        y      = '0;
        c_o    = 1'b0;
        v_o    = 1'b0;
        cv_upd = 1'b1;
        unique case (op)
            A_ADD: begin
                ext = {1'b0, a} + {1'b0, b};
                y = ext[W-1:0]; c_o = ext[W];
                v_o = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            A_SUB: begin
                ext = {1'b0, a} - {1'b0, b};
                y = ext[W-1:0]; c_o = ext[W];
                v_o = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            A_INC: begin
                ext = {1'b0, a} + ONE_X;
                y = ext[W-1:0]; c_o = ext[W];
                v_o = !a[W-1] && y[W-1];
            end
            A_CLR: y = '0;
            A_AND: begin y = a & b; cv_upd = 1'b0; end
            A_OR:  begin y = a | b; cv_upd = 1'b0; end
            A_XOR: begin y = a ^ b; cv_upd = 1'b0; end
            A_NOT: begin y = ~a;    cv_upd = 1'b0; end
            A_LSL: begin y = {a[W-2:0], 1'b0};   c_o = a[W-1]; v_o = y[W-1] ^ a[W-1]; end
            A_LSR: begin y = {1'b0, a[W-1:1]};   c_o = a[0];   v_o = y[W-1] ^ a[W-1]; end
            A_RL:  begin y = {a[W-2:0], a[W-1]}; c_o = a[W-1]; v_o = y[W-1] ^ a[W-1]; end
            A_RR:  begin y = {a[0], a[W-1:1]};   c_o = a[0];   v_o = y[W-1] ^ a[W-1]; end
            default: cv_upd = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          halted
);
    localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};

    state_e        state, nxt;
    logic [AW-1:0] pc, ar;
    logic [DW-1:0] dr, tr, ir, ac, r;
    logic          fz, fc, fv, fn;

    logic [7:0]    dec_in;
    kind_e         kind;
    alu_op_e       aop;
    cond_e         cond;
    logic [DW-1:0] alu_y;
    logic          alu_c, alu_v, alu_cv;
    logic          take;

    // Decode the byte being dispatched in S_F3, otherwise the held opcode.
    assign dec_in = (state == S_F3) ? dr : ir;

    acc_cpu_dec dec_i (.opc(dec_in), .kind(kind), .aop(aop), .cond(cond));

    acc_cpu_alu #(.W(DW)) alu_i (
        .op(aop), .a(ac), .b(r), .y(alu_y),
        .c_o(alu_c), .v_o(alu_v), .cv_upd(alu_cv)
    );

    always_comb begin
        unique case (cond)
            J_Z:     take = fz;
            J_NZ:    take = !fz;
            J_C:     take = fc;
            J_V:     take = fv;
            J_N:     take = fn;
            default: take = 1'b1;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_F1;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_F1:  nxt = S_F2;
            S_F2:  nxt = S_F3;
            S_F3: begin
                unique case (kind)
                    K_LDAC, K_STAC, K_JMP: nxt = S_A1;
                    K_MVI:                 nxt = S_IM1;
                    K_MVAC, K_MOVR, K_ALU: nxt = S_EX;
                    K_HALT:                nxt = S_HLT;
                    default:               nxt = S_F1;
                endcase
            end
            S_A1:  nxt = S_A2;
            S_A2:  nxt = (kind == K_JMP) ? S_JP3 : S_A3;
            S_A3:  nxt = (kind == K_LDAC) ? S_LD4 : S_ST4;
            S_LD4: nxt = S_LD5;
            S_ST4: nxt = S_ST5;
            S_IM1: nxt = S_IM2;
            S_HLT: nxt = S_HLT;
            default: nxt = S_F1;
        endcase
    end

    // Datapath register transfers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0; ar <= '0; dr <= '0; tr <= '0; ir <= '0; ac <= '0; r <= '0;
            fz <= 1'b0; fc <= 1'b0; fv <= 1'b0; fn <= 1'b0;
        end else begin
            unique case (state)
                S_F1:  ar <= pc;
                S_F2:  begin dr <= mem_rdata; pc <= pc + ONE_A; end
                S_F3:  begin ir <= dr; ar <= pc; end
                S_A1:  begin dr <= mem_rdata; pc <= pc + ONE_A; ar <= ar + ONE_A; end
                S_A2:  begin tr <= dr; dr <= mem_rdata; pc <= pc + ONE_A; end
                S_A3:  ar <= {tr, dr};
                S_LD4: dr <= mem_rdata;
                S_LD5: ac <= dr;
                S_ST4: dr <= ac;
                S_JP3: if (take) pc <= {tr, dr};
                S_IM1: begin dr <= mem_rdata; pc <= pc + ONE_A; end
                S_IM2: ac <= dr;
                S_EX: begin
                    unique case (kind)
                        K_MVAC: r  <= ac;
                        K_MOVR: ac <= r;
                        K_ALU: begin
                            ac <= alu_y;
                            fz <= (alu_y == '0);
                            fn <= alu_y[DW-1];
                            if (alu_cv) begin fc <= alu_c; fv <= alu_v; end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = ar;
        mem_wdata = dr;
        mem_we    = (state == S_ST5);
        halted    = (state == S_HLT);
    end

    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_wdata_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == ac));
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(mem_addr)));
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F2) |=> (pc == $past(pc) + ONE_A));
    p_untaken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JP3 && !take) |=> $stable(pc));
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EX && kind == K_ALU) |=> (fz == (ac == '0)));
endmodule

// File: tb/acc_cpu_seq_tb_top.sv
module acc_cpu_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we, halted;

    logic [7:0]  mem [0:4095];
    logic [7:0]  prog [0:511];
    logic        ld_en = 1'b0;
    logic [11:0] ld_a = '0;
    logic [7:0]  ld_d = '0;
    int          pa, checks, errs;
    logic [15:0] gaddr;

    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } wr_t;
    wr_t sb [$];
    wr_t e;

    always #4 clk = ~clk;

    acc_cpu_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (ld_en) mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each write with the next expected item
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4/R7 unexpected write", {mem_addr, mem_wdata}, 32'h0);
            end else begin
                e = sb.pop_front();
                chk(mem_addr == e.a && mem_wdata == e.d, e.tag, {mem_addr, mem_wdata}, {e.a, e.d});
            end
        end
    end

    // Assembler helpers (driver side of the scoreboard)
    task automatic b1(input logic [7:0] v); prog[pa] = v; pa++; endtask
    task automatic b3(input logic [7:0] op, input logic [15:0] ad);
        b1(op); b1(ad[15:8]); b1(ad[7:0]);
    endtask
    task automatic mvi(input logic [7:0] v); b1(8'h13); b1(v); endtask
    task automatic st(input logic [7:0] exp, input string tag);
        wr_t w;
        b3(8'h02, gaddr);
        w.a = gaddr; w.d = exp; w.tag = tag;
        sb.push_back(w);
        gaddr++;
    endtask
    task automatic jt(input logic [7:0] op, input bit taken, input logic [7:0] exp, input string tag);
        logic [15:0] tgt;
        tgt = 16'(pa + 6);
        b3(op, tgt);
        if (taken) b3(8'h02, 16'h0FEE);
        else st(exp, tag);
    endtask

    task automatic load_prog();
        rst_n = 1'b0;
        for (int i = 0; i < pa; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_a = 12'(i); ld_d = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(output int n);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_addr == 16'h0000, "R1 first fetch address", mem_addr, 0);
        n = 0;
        while (!halted && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] hold;
        checks = 0; errs = 0;
        gaddr = 16'h0F00;

        // Main program
        pa = 0;
        mvi(8'h7F); b1(8'h03); mvi(8'h01); b1(8'h08);       // ADD -> 80, V N
        st(8'h80, "R8 add overflow result");
        jt(8'h11, 1, 0, "");                                 // JMPV taken
        jt(8'h12, 1, 0, "");                                 // JMPN taken
        jt(8'h10, 0, 8'h80, "R7 JMPC not taken");
        jt(8'h06, 0, 8'h80, "R7 JMPZ not taken");
        jt(8'h07, 1, 0, "");                                 // JPNZ taken
        mvi(8'h00); b1(8'h09);                               // SUB 0-7F -> 81, C
        st(8'h81, "R8 sub borrow result");
        jt(8'h10, 1, 0, "");
        jt(8'h11, 0, 8'h81, "R8 sub no overflow");
        mvi(8'hFF); b1(8'h0A);                               // INAC -> 00, C Z
        st(8'h00, "R8 inac wrap");
        jt(8'h06, 1, 0, "");
        jt(8'h07, 0, 8'h00, "R7 JPNZ not taken");
        jt(8'h10, 1, 0, "");
        mvi(8'h80); b1(8'h03); mvi(8'h80); b1(8'h08);        // ADD 80+80 -> 00, C V Z
        jt(8'h11, 1, 0, "");
        mvi(8'h55); b1(8'h0B);                               // CLAC
        jt(8'h10, 0, 8'h00, "R8 CLAC clears C");
        jt(8'h06, 1, 0, "");
        mvi(8'h81); b1(8'h14);                               // LSL -> 02, C V
        st(8'h02, "R10 LSL result");
        jt(8'h10, 1, 0, "");
        mvi(8'h0F); b1(8'h03); mvi(8'h81); b1(8'h0C);        // AND -> 01
        st(8'h01, "R9 AND result");
        jt(8'h10, 1, 0, "");                                 // R9 C kept
        jt(8'h11, 1, 0, "");                                 // R9 V kept
        mvi(8'hF0); b1(8'h0D);
        st(8'hFF, "R9 OR result");
        jt(8'h12, 1, 0, "");
        mvi(8'h3C); b1(8'h0E);
        st(8'h33, "R9 XOR result");
        b1(8'h0F);
        st(8'hCC, "R9 NOT result");
        mvi(8'h81); b1(8'h16);
        st(8'h03, "R10 RL result");
        mvi(8'h81); b1(8'h15);
        st(8'h40, "R10 LSR result");
        mvi(8'h01); b1(8'h17);
        st(8'h80, "R10 RR result");
        mvi(8'h40); b1(8'h16);                               // RL -> 80, C=0 V=1
        jt(8'h10, 0, 8'h80, "R10 RL carry clear");
        jt(8'h11, 1, 0, "");
        mvi(8'h02); b1(8'h15);                               // LSR -> 01, V=0
        jt(8'h11, 0, 8'h01, "R10 LSR no sign change");
        b1(8'h04);
        st(8'h0F, "R5 MOVR copies R");
        b1(8'h00); b1(8'h20);
        mvi(8'h66);
        st(8'h66, "R2 NOP and unknown opcode continue, R5 MVI");
        b3(8'h01, 16'h0F00);
        st(8'h80, "R3 LDAC loads stored byte");
        b3(8'h05, 16'(pa + 6));
        b3(8'h02, 16'h0FEE);                                 // R6 skipped
        b1(8'hFF);
        load_prog();
        chk(!halted && !mem_we, "R1 outputs low in reset", {halted, mem_we}, 0);
        run(n);
        chk(halted == 1'b1, "R11 main program halts", halted, 1);
        hold = mem_addr;
        repeat (20) @(negedge clk);
        chk(halted && mem_addr == hold, "R11 halt is sticky", {halted, mem_addr}, {1'b1, hold});
        chk(sb.size() == 0, "R7 all expected writes seen", sb.size(), 0);
        sb.delete();

        // Timing: NOP NOP HALT
        pa = 0; b1(8'h00); b1(8'h00); b1(8'hFF);
        load_prog();
        chk(!halted, "R1 reset clears halted", halted, 0);
        run(n);
        chk(n == 9, "R2 NOP and fetch cycles", n, 9);

        // Timing: LDAC then HALT
        pa = 0; b3(8'h01, 16'h0F00); b1(8'hFF);
        load_prog();
        run(n);
        chk(n == 11, "R3 LDAC cycles", n, 11);

        // Timing: MVI, MVAC, JUMP, HALT
        pa = 0; mvi(8'h12); b1(8'h03); b3(8'h05, 16'(pa + 3)); b1(8'hFF);
        load_prog();
        run(n);
        chk(n == 18, "R12 R6 summed cycle counts", n, 18);

        // Timing: STAC then HALT
        pa = 0; st(8'h00, "R4 STAC after reset writes AC=0"); b1(8'hFF);
        load_prog();
        run(n);
        chk(n == 11, "R4 STAC cycles", n, 11);
        chk(sb.size() == 0, "R4 store seen", sb.size(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule